// File: doc/BRIEF.md
# LIN Node Address Assignment Handler

This block decides whether a received LIN diagnostic master request assigns a new node address to the slave. It does not read the bus bit by bit. A frame receiver hands it the eight payload bytes of a finished master request together with a one-cycle valid strobe. The block checks the addressing byte, the service code and the fixed supplier and function codes, and a candidate address carried in the last byte. When all checks pass, it stores that candidate as the node address and presents the bytes of a positive slave response for one cycle.

Three acceptance schemes are available, chosen by a mode input that is applied at reset:

- **Standard mode.** The request must address the node by its current address or by the wildcard.
- **Daisy-chain mode.** Nodes start at a shared initial address. Only the node whose chain input pin is low and whose chain switch is open takes the address. On success that node signals that its switch is to close, which opens the chain to the next node.
- **Plug-coding mode.** The first byte does not hold an address. It holds a code that must match the three strapped configuration pins.

Top module: `lin_nad_assign`

## Requirements
- R1: Reset is synchronous and active low (`rstN`). During reset `nad` loads 0x10 when `mode` is 2'b00 (standard) or 2'b11 (also standard), 0x21 when `mode` is 2'b01 (daisy chain), and 0x20 when `mode` is 2'b10 (plug coding). `respValid` and `chainClose` are 0 after reset.
- R2: Byte k of `frameData` is bits [8k+7:8k]. In standard mode, a strobed request is accepted when all of the following hold: byte 0 equals `nad` or 0x7F, byte 2 is 0xB0, bytes 3..6 are 0x11, 0x00, 0x00, 0x00, and byte 7 is a legal address. On acceptance, `nad` takes byte 7 at the next clock edge and `respValid` is high for exactly that one cycle.
- R3: On acceptance, `respData` holds the following bytes, with byte k at bits [8k+7:8k]:

  | Byte | Value |
  |------|-------|
  | 0 | the address held before the request |
  | 1 | 0x05 |
  | 2 | 0xF0 |
  | 3 | 0x11 |
  | 4 | 0x00 |
  | 5 | 0x00 |
  | 6 | 0x00 |
  | 7 | 0xFF |

- R4: A request whose service byte, supplier bytes or function bytes differ from the codes in R2 leaves `nad` unchanged and raises no `respValid`.
- R5: In standard mode, a request whose byte 0 is neither `nad` nor 0x7F is ignored. A request with byte 0 equal to 0x7F is accepted whatever the current address.
- R6: After an assignment, requests addressed to the new address are accepted, and requests addressed to the previous address are ignored.
- R7: A candidate address of 0x00, or of 0x80 and above, is never stored and produces no response.
- R8: In plug mode, byte 0 must have bits [7:4] equal to 0, bit 3 equal to 1, and bits [2:0] equal to `cfgPins` (bit 2 = C3, bit 0 = C1). Any mismatch rejects the request.
- R9: In daisy-chain mode, a request is accepted only when all of the following hold: byte 0 addresses the node (as in R2), `cfgPins[0]` is 0, and `chainOpen` is 1.
- R10: `chainClose` rises after a successful daisy-chain assignment and stays high until reset. It never rises in the other modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Assignment scheme, applied at reset and used for acceptance |
| frameValid | input | 1 | One-cycle strobe marking a complete master request |
| frameData | input | 64 | Request payload, byte k at [8k+7:8k] |
| cfgPins | input | 3 | Strapped configuration pin levels, bit 0 = C1 |
| chainOpen | input | 1 | High while the node's chain switch is open |
| nad | output | 8 | Current node address |
| respData | output | 64 | Positive response payload, byte k at [8k+7:8k] |
| respValid | output | 1 | One-cycle pulse when a request was accepted |
| chainClose | output | 1 | Request to close the chain switch |

## Verification
A sequence of standard-mode requests is applied, each differing from a good frame in a single field: the addressing byte, the service code, a supplier byte, a function byte, or a candidate address at a boundary (0x00, 0x7F, 0x80). This shows that each check can reject a request on its own. The sequence also moves the address several times, which tells the wildcard apart from a genuine address match and shows that the old address stops working. Plug mode is tried with codes that fail on the pins, on the upper nibble and on bit 3. Daisy-chain mode is tried with the pin high, with the switch closed and with both conditions satisfied, which shows that each gate is needed.

// File: rtl/lin_nad_assign_pkg.sv
package lin_nad_assign_pkg;

  localparam int NAD_W = 8;

  typedef enum logic [1:0] {
    MODE_STD   = 2'b00,
    MODE_CHAIN = 2'b01,
    MODE_PLUG  = 2'b10,
    MODE_ALT   = 2'b11
  } assignMode_e;

  localparam logic [NAD_W-1:0] SID_ASSIGN  = 8'hB0;
  localparam logic [NAD_W-1:0] RSID_ASSIGN = 8'hF0;
  localparam logic [NAD_W-1:0] NAD_WILD    = 8'h7F;
  localparam logic [NAD_W-1:0] RESP_PCI    = 8'h05;
  localparam logic [NAD_W-1:0] RESP_FILL   = 8'hFF;
  localparam logic [15:0]      SUPPLIER_ID = 16'h0011;
  localparam logic [15:0]      FUNCTION_ID = 16'h0000;

  typedef struct packed {
    logic loadNad;
    logic loadResp;
    logic closeChain;
  } ctrlStrobes_t;

  typedef struct packed {
    logic addrHit;
    logic plugHit;
    logic svcHit;
    logic nadLegal;
  } matchFlags_t;

endpackage

// File: rtl/lin_nad_assign_dp.sv
module lin_nad_assign_dp
  import lin_nad_assign_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int PIN_COUNT = 3,
  parameter logic [NAD_W-1:0] STD_INIT_NAD = 8'h10,
  parameter logic [NAD_W-1:0] CHAIN_INIT_NAD = 8'h21,
  parameter logic [NAD_W-1:0] PLUG_INIT_NAD = 8'h20,
  localparam int FRAME_W = FRAME_BYTES * NAD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic [FRAME_W-1:0]   frameData,
  input  logic [PIN_COUNT-1:0] cfgPins,
  input  ctrlStrobes_t         strobes,
  output logic [NAD_W-1:0]     nad,
  output logic [FRAME_W-1:0]   respData,
  output matchFlags_t          flags
);

  logic [NAD_W-1:0] rxByte   [FRAME_BYTES];
  logic [NAD_W-1:0] respByte [FRAME_BYTES];
  logic [FRAME_W-1:0] respNext;
  logic [NAD_W-1:0] initNad;

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_bytes
    assign rxByte[g] = frameData[g*NAD_W +: NAD_W];
    assign respNext[g*NAD_W +: NAD_W] = respByte[g];
  end

  always_comb begin
    flags.addrHit  = (rxByte[0] == nad) || (rxByte[0] == NAD_WILD);
    flags.svcHit   = (rxByte[2] == SID_ASSIGN) &&
                     ({rxByte[4], rxByte[3]} == SUPPLIER_ID) &&
                     ({rxByte[6], rxByte[5]} == FUNCTION_ID);
    flags.nadLegal = (rxByte[FRAME_BYTES-1] != '0) && !rxByte[FRAME_BYTES-1][NAD_W-1];
    flags.plugHit  = (rxByte[0][NAD_W-1:PIN_COUNT+1] == '0) && rxByte[0][PIN_COUNT] &&
                     (rxByte[0][PIN_COUNT-1:0] == cfgPins);
  end

  always_comb begin
    for (int i = 0; i < FRAME_BYTES; i++) respByte[i] = RESP_FILL;
    respByte[0] = nad;
    respByte[1] = RESP_PCI;
    respByte[2] = RSID_ASSIGN;
    respByte[3] = SUPPLIER_ID[7:0];
    respByte[4] = SUPPLIER_ID[15:8];
    respByte[5] = FUNCTION_ID[7:0];
    respByte[6] = FUNCTION_ID[15:8];
  end

  always_comb begin
    unique case (assignMode_e'(mode))
      MODE_CHAIN: initNad = CHAIN_INIT_NAD;
      MODE_PLUG:  initNad = PLUG_INIT_NAD;
      default:    initNad = STD_INIT_NAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nad      <= initNad;
      respData <= '0;
    end else begin
      if (strobes.loadNad)  nad      <= rxByte[FRAME_BYTES-1];
      if (strobes.loadResp) respData <= respNext;
    end
  end

  // R7
  nad_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (nad != '0) && !nad[NAD_W-1]);

endmodule

// File: rtl/lin_nad_assign_ctrl.sv
module lin_nad_assign_ctrl
  import lin_nad_assign_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   mode,
  input  logic         frameValid,
  input  matchFlags_t  flags,
  input  logic         pinC1,
  input  logic         chainOpen,
  output ctrlStrobes_t strobes,
  output logic         respValid,
  output logic         chainClose
);

  logic baseOk;
  logic accept;

  always_comb begin
    baseOk = frameValid && flags.svcHit && flags.nadLegal;
    unique case (assignMode_e'(mode))
      MODE_CHAIN: accept = baseOk && flags.addrHit && !pinC1 && chainOpen;
      MODE_PLUG:  accept = baseOk && flags.plugHit;
      default:    accept = baseOk && flags.addrHit;
    endcase
    strobes.loadNad    = accept;
    strobes.loadResp   = accept;
    strobes.closeChain = accept && (assignMode_e'(mode) == MODE_CHAIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      chainClose <= 1'b0;
    end else begin
      respValid  <= accept;
      chainClose <= chainClose || strobes.closeChain;
    end
  end

  // R2
  resp_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(frameValid));

  // R10
  chain_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chainClose) |-> ($past(mode) == MODE_CHAIN));

  // R10
  chain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    chainClose |=> chainClose);

endmodule

// File: rtl/lin_nad_assign.sv
module lin_nad_assign
  import lin_nad_assign_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  parameter int PIN_COUNT = 3,
  localparam int FRAME_W = FRAME_BYTES * NAD_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           mode,
  input  logic                 frameValid,
  input  logic [FRAME_W-1:0]   frameData,
  input  logic [PIN_COUNT-1:0] cfgPins,
  input  logic                 chainOpen,
  output logic [NAD_W-1:0]     nad,
  output logic [FRAME_W-1:0]   respData,
  output logic                 respValid,
  output logic                 chainClose
);

  ctrlStrobes_t strobes;
  matchFlags_t  flags;

  lin_nad_assign_dp #(.FRAME_BYTES(FRAME_BYTES), .PIN_COUNT(PIN_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .mode(mode), .frameData(frameData), .cfgPins(cfgPins),
    .strobes(strobes), .nad(nad), .respData(respData), .flags(flags)
  );

  lin_nad_assign_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .frameValid(frameValid), .flags(flags),
    .pinC1(cfgPins[0]), .chainOpen(chainOpen), .strobes(strobes),
    .respValid(respValid), .chainClose(chainClose)
  );

  // R2
  nad_from_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (nad == $past(frameData[FRAME_W-1 -: NAD_W])));

  // R4
  nad_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> $stable(nad));

endmodule

// File: tb/lin_nad_assign_bench.sv
`timescale 1ns/1ps
module lin_nad_assign_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        frameValid = 1'b0;
  logic [63:0] frameData = '0;
  logic [2:0]  cfgPins = 3'b000;
  logic        chainOpen = 1'b0;
  logic [7:0]  nad;
  logic [63:0] respData;
  logic        respValid;
  logic        chainClose;

  int vecCnt = 0;
  int missCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lin_nad_assign u_lin_nad_assign (
    .clk(clk), .rstN(rstN), .mode(mode), .frameValid(frameValid), .frameData(frameData),
    .cfgPins(cfgPins), .chainOpen(chainOpen), .nad(nad), .respData(respData),
    .respValid(respValid), .chainClose(chainClose)
  );

  // frame layout {D7,D6,D5,D4,D3,D2,D1,D0}
  localparam int NVEC = 10;
  localparam logic [63:0] VEC_FRAME [NVEC] = '{
    64'h05000000_11B00610,  // R2 accept via current address
    64'h06000000_11B00610,  // R6 old address no longer valid
    64'h7F000000_11B0067F,  // R5 wildcard, candidate 0x7F legal
    64'h44000000_11B1067F,  // R4 wrong service
    64'h44000000_12B0067F,  // R4 wrong supplier
    64'h44000100_11B0067F,  // R4 wrong function
    64'h80000000_11B0067F,  // R7 candidate 0x80
    64'h00000000_11B0067F,  // R7 candidate 0x00
    64'h33000000_11B0067F,  // R5 wildcard again
    64'h01000000_11B00633   // R6 new address addresses node
  };
  localparam logic [7:0] VEC_NAD [NVEC] = '{8'h05, 8'h05, 8'h7F, 8'h7F, 8'h7F,
                                           8'h7F, 8'h7F, 8'h7F, 8'h33, 8'h01};
  localparam logic VEC_OK [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
                                     1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  string vecReq [NVEC] = '{"R2", "R6", "R5", "R4", "R4", "R4", "R7", "R7", "R5", "R6"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecCnt++;
    if (act !== exp) begin
      missCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] respOf(input logic [7:0] oldNad);
    return {8'hFF, 8'h00, 8'h00, 8'h00, 8'h11, 8'hF0, 8'h05, oldNad};
  endfunction

  task automatic doReset(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drive one strobed frame; return at the negedge after the capturing edge
  task automatic sendFrame(input logic [63:0] f);
    @(negedge clk);
    frameData = f;
    frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  task automatic tryFrame(input string req, input logic [63:0] f, input logic [7:0] expNad,
                          input logic ok, input logic [7:0] oldNad);
    sendFrame(f);
    chk(req, {56'd0, nad}, {56'd0, expNad});
    chk(req, {63'd0, respValid}, {63'd0, ok});
    if (ok) chk("R3", respData, respOf(oldNad));
    @(negedge clk);
    chk(req, {63'd0, respValid}, 64'd0);
  endtask

  initial begin
    logic [7:0] prevNad;
    // R1 reset values per mode
    doReset(2'b01);
    chk("R1", {56'd0, nad}, 64'h21);
    doReset(2'b10);
    chk("R1", {56'd0, nad}, 64'h20);
    doReset(2'b00);
    chk("R1", {56'd0, nad}, 64'h10);
    chk("R1", {62'd0, respValid, chainClose}, 64'd0);

    prevNad = 8'h10;
    for (int v = 0; v < NVEC; v++) begin
      tryFrame(vecReq[v], VEC_FRAME[v], VEC_NAD[v], VEC_OK[v], prevNad);
      prevNad = VEC_NAD[v];
    end
    chk("R10", {63'd0, chainClose}, 64'd0);

    // R8 plug coding, pins C3..C1 = 101
    cfgPins = 3'b101;
    doReset(2'b10);
    tryFrame("R8", 64'h45000000_11B0060D, 8'h45, 1'b1, 8'h20);
    tryFrame("R8", 64'h46000000_11B0060C, 8'h45, 1'b0, 8'h45);
    tryFrame("R8", 64'h46000000_11B0061D, 8'h45, 1'b0, 8'h45);
    tryFrame("R8", 64'h46000000_11B00605, 8'h45, 1'b0, 8'h45);
    tryFrame("R8", 64'h46000000_11B00645, 8'h45, 1'b0, 8'h45);
    chk("R10", {63'd0, chainClose}, 64'd0);

    // R9 daisy chain gating
    doReset(2'b01);
    cfgPins = 3'b001;
    chainOpen = 1'b1;
    tryFrame("R9", 64'h30000000_11B00621, 8'h21, 1'b0, 8'h21);
    cfgPins = 3'b000;
    chainOpen = 1'b0;
    tryFrame("R9", 64'h30000000_11B00621, 8'h21, 1'b0, 8'h21);
    chk("R10", {63'd0, chainClose}, 64'd0);
    chainOpen = 1'b1;
    tryFrame("R9", 64'h30000000_11B00621, 8'h30, 1'b1, 8'h21);
    chk("R10", {63'd0, chainClose}, 64'd1);
    repeat (3) @(negedge clk);
    chk("R10", {63'd0, chainClose}, 64'd1);
    doReset(2'b01);
    chk("R10", {63'd0, chainClose}, 64'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vecCnt++;
      missCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

endmodule